// File: doc/BRIEF.md
# Phase-Aligned Serial Clock and Data Transmitter

This block drives the transmit side of a synchronous serial link from two cooperating engines that share one divider setting. The clock engine runs a phase counter that keeps wrapping on a fixed grid of `period` system clocks for as long as it is enabled. A pulse request arms a count of pulses. Each pulse fills exactly one grid period: the line is high for `high_ticks` cycles and low for the rest, so the duty cycle need not be even. The polarity input inverts the line to give an idle-high clock.

The data engine is different. Its bit timer only runs while it has work. A start strobe launches at once: first a quiet preamble of a programmable number of system clocks, then the low `tx_bits` bits of the word, most significant first, each lasting one period. When the divider is not a power of two, the first data bit lasts one extra system clock.

Because one grid runs freely and the other starts on demand, software lines them up itself. It restarts the clock engine's phase, either through the restart strobe or by disabling and re-enabling it, in the same cycle as the start strobe. It then picks the preamble length for the divider in use, so that data edges fall on the wanted clock edge.

Top module: `phase_aligned_tx`

## Requirements
- R1: While reset is asserted and right after it, `sck` equals `cpol`, `sdo` is 0 and `busy` is 0.
- R2: When the clock is enabled and a pulse request with count N arrives in the same cycle, `sck` (with `cpol`=0) is high during cycles k·P to k·P+H−1 and low otherwise, for k = 0..N−1, counted from the first cycle after that edge. P is the period and H is `high_ticks`. After the N periods it stays low.
- R3: While enabled with no pulses, the phase counter keeps wrapping every P cycles. A request issued mid-period produces its first pulse only at the next period boundary of that running grid.
- R4: A `ck_restart` strobe while enabled resets the phase to zero. If a request arrives in the same cycle, its first pulse starts in the first cycle after the strobe.
- R5: With `ck_enable` low, `sck` rests at its idle level, pending pulses are dropped and requests are ignored. Enabling again restarts the grid at phase zero without any pulse.
- R6: `cpol`=1 inverts `sck`: it idles high and each pulse is a low interval of H cycles.
- R7: A start with `tx_delay`=0 puts the first data bit on `sdo` in the first cycle after the start edge.
- R8: A start with `tx_delay`=D holds `sdo` at 0 for D cycles after the start edge, and then the first data bit appears.
- R9: Data bits are `tx_word[tx_bits-1]` down to `tx_word[0]`, each held for P cycles. After the last bit, `sdo` returns to 0.
- R10: If P is not a power of two, the first data bit lasts P+1 cycles. If P is a power of two, it lasts P cycles.
- R11: `tx_go` is ignored while a stream (preamble or data) is in progress, and also when `tx_bits` is 0.
- R12: `busy` is 1 from the cycle after a start or a request until both the last data bit and the last pulse period have ended, and 0 in the cycle after that.
- R13: A `period` below 2 is treated as 2 by both engines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period | input | DIV_W | Divider ratio P in system clocks, shared by both engines |
| high_ticks | input | DIV_W | High time H of a pulse, in system clocks |
| cpol | input | 1 | Clock polarity; 1 inverts `sck` |
| ck_enable | input | 1 | Clock engine enable; low clears it, a rising level restarts the phase |
| ck_restart | input | 1 | Strobe that resets the clock phase to zero |
| pulse_go | input | 1 | Strobe that loads a pulse count |
| pulse_num | input | CNT_W | Number of pulses requested |
| tx_go | input | 1 | Strobe that starts a data stream |
| tx_delay | input | DLY_W | Preamble length in system clocks |
| tx_word | input | DATA_W | Data word to send |
| tx_bits | input | BITS_W | Number of low-order bits of `tx_word` to send |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data |
| busy | output | 1 | Either engine has work outstanding |

## Verification
The bench targets the timing edges where an off-by-one hides. It issues a request mid-grid; a design that restarted the phase on request would pulse at once instead of waiting for the boundary. It compares zero and non-zero preambles; a design with an extra register stage would shift every data edge by a cycle. It runs dividers 4 and 6 side by side, so a design that dropped or misapplied the first-bit stretch shows up as a one-cycle drift across all following bits. It also disables the clock with pulses still pending, strobes start during a running stream and with a zero bit count, and drives sub-minimum periods. A design that leaked old pulses, restarted the stream or divided by one would change `sck`, `sdo` or `busy` where the bench expects them to hold still.

// File: rtl/sas_pkg.sv
package sas_pkg;

    // Smallest divider either engine accepts.
    localparam int unsigned MIN_DIV = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_DATA = 2'd2
    } str_state_e;

    // True when v has at most one bit set.
    function automatic logic is_pow2(input logic [31:0] v);
        return ((v & (v - 32'd1)) == 32'd0);
    endfunction

endpackage

// File: rtl/sas_clk_gen.sv
module sas_clk_gen #(
    parameter int DIV_W = 5,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] period,
    input  logic [DIV_W-1:0] high_ticks,
    input  logic             en,
    input  logic             restart,
    input  logic             pulse_go,
    input  logic [CNT_W-1:0] pulse_num,
    output logic             sck_raw,
    output logic             busy
);
    import sas_pkg::*;

    typedef struct packed {
        logic [DIV_W-1:0] ph;       // phase inside the current period
        logic [CNT_W-1:0] left;     // pulses still to be emitted
        logic             active;   // current period carries a pulse
        logic             raw;      // registered line level before polarity
        logic             en_seen;  // enable was high last cycle
    } cg_state_t;

    cg_state_t q, d;
    logic [DIV_W-1:0] p_eff, p_m1;
    logic [CNT_W-1:0] eff_left;
    logic             boundary;

    always_comb begin
        p_eff    = (period < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : period;
        p_m1     = p_eff - DIV_W'(1);
        eff_left = pulse_go ? pulse_num : q.left;
        boundary = !q.en_seen || restart || (q.ph >= p_m1);
        d        = q;
        if (!en) begin
            d.ph      = '0;
            d.left    = '0;
            d.active  = 1'b0;
            d.raw     = 1'b0;
            d.en_seen = 1'b0;
        end else begin
            d.en_seen = 1'b1;
            if (boundary) begin
                d.ph = '0;
                if (eff_left != '0) begin
                    d.active = 1'b1;
                    d.left   = eff_left - CNT_W'(1);
                end else begin
                    d.active = 1'b0;
                    d.left   = '0;
                end
            end else begin
                d.ph   = q.ph + DIV_W'(1);
                d.left = eff_left;
            end
            d.raw = d.active && (d.ph < high_ticks);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sck_raw = q.raw;
    assign busy    = q.active || (q.left != '0);

    assert_restart_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && restart) |=> (q.ph == '0));

    assert_off_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> (!sck_raw && !busy));

    assert_no_early_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && q.en_seen && !restart && (q.ph < p_m1) && !q.active) |=> !q.active);

    assert_pulse_starts_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $rose(q.active) && (high_ticks != '0)) |-> sck_raw);

endmodule

// File: rtl/sas_streamer.sv
module sas_streamer #(
    parameter int DIV_W        = 5,
    parameter int DLY_W        = 16,
    parameter int DATA_W       = 32,
    parameter bit EXTEND_FIRST = 1'b1,
    localparam int BITS_W      = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  period,
    input  logic              tx_go,
    input  logic [DLY_W-1:0]  tx_delay,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [BITS_W-1:0] tx_bits,
    output logic              sdo,
    output logic              busy
);
    import sas_pkg::*;

    typedef struct packed {
        str_state_e        st;
        logic [DLY_W-1:0]  tick;   // cycles left in the current slot minus one
        logic [DATA_W-1:0] sh;     // remaining bits, next one at the top
        logic [BITS_W-1:0] left;   // bits still to be sent after the current
        logic              sdo;
    } st_state_t;

    st_state_t q, d;
    logic [DIV_W-1:0]  p_eff;
    logic              ext;
    logic [BITS_W-1:0] shamt;
    logic [DATA_W-1:0] aligned;
    logic [DATA_W-1:0] src_sh;
    logic [BITS_W-1:0] src_left;
    logic              launch;
    logic              accept;

    assign p_eff = (period < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : period;

    generate
        if (EXTEND_FIRST) begin : g_stretch
            assign ext = !is_pow2(32'(p_eff));
        end else begin : g_plain
            assign ext = 1'b0;
        end
    endgenerate

    always_comb begin
        shamt    = BITS_W'(DATA_W) - tx_bits;
        aligned  = tx_word << shamt;
        accept   = tx_go && (tx_bits != '0) && (q.st == ST_IDLE);
        launch   = 1'b0;
        src_sh   = q.sh;
        src_left = q.left;
        d        = q;
        case (q.st)
            ST_IDLE: begin
                d.sdo = 1'b0;
                if (accept) begin
                    d.sh   = aligned;
                    d.left = tx_bits;
                    if (tx_delay == '0) begin
                        launch   = 1'b1;
                        src_sh   = aligned;
                        src_left = tx_bits;
                    end else begin
                        d.st   = ST_PRE;
                        d.tick = tx_delay - DLY_W'(1);
                    end
                end
            end
            ST_PRE: begin
                d.sdo = 1'b0;
                if (q.tick == '0) begin
                    launch = 1'b1;
                end else begin
                    d.tick = q.tick - DLY_W'(1);
                end
            end
            ST_DATA: begin
                if (q.tick != '0) begin
                    d.tick = q.tick - DLY_W'(1);
                end else if (q.left == '0) begin
                    d.st  = ST_IDLE;
                    d.sdo = 1'b0;
                end else begin
                    d.sdo  = q.sh[DATA_W-1];
                    d.sh   = q.sh << 1;
                    d.left = q.left - BITS_W'(1);
                    d.tick = DLY_W'(p_eff) - DLY_W'(1);
                end
            end
            default: begin
                d.st  = ST_IDLE;
                d.sdo = 1'b0;
            end
        endcase
        if (launch) begin
            d.st   = ST_DATA;
            d.sdo  = src_sh[DATA_W-1];
            d.sh   = src_sh << 1;
            d.left = src_left - BITS_W'(1);
            d.tick = DLY_W'(p_eff) - DLY_W'(1) + DLY_W'(ext);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, tick: '0, sh: '0, left: '0, sdo: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sdo  = q.sdo;
    assign busy = (q.st != ST_IDLE);

    assert_pre_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PRE) |-> !sdo);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !sdo);

    assert_bit_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_DATA) && (q.tick != '0)) |=> $stable(sdo));

    assert_go_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_PRE) && (q.tick != '0) && tx_go) |=> (q.st == ST_PRE));

endmodule

// File: rtl/phase_aligned_tx.sv
module phase_aligned_tx #(
    parameter int DIV_W        = 5,
    parameter int CNT_W        = 16,
    parameter int DLY_W        = 16,
    parameter int DATA_W       = 32,
    parameter bit EXTEND_FIRST = 1'b1,
    localparam int BITS_W      = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  period,
    input  logic [DIV_W-1:0]  high_ticks,
    input  logic              cpol,
    input  logic              ck_enable,
    input  logic              ck_restart,
    input  logic              pulse_go,
    input  logic [CNT_W-1:0]  pulse_num,
    input  logic              tx_go,
    input  logic [DLY_W-1:0]  tx_delay,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [BITS_W-1:0] tx_bits,
    output logic              sck,
    output logic              sdo,
    output logic              busy
);
    logic cg_raw, cg_busy, st_busy;

    sas_clk_gen #(
        .DIV_W (DIV_W),
        .CNT_W (CNT_W)
    ) u_clk (
        .clk        (clk),
        .rst_n      (rst_n),
        .period     (period),
        .high_ticks (high_ticks),
        .en         (ck_enable),
        .restart    (ck_restart),
        .pulse_go   (pulse_go),
        .pulse_num  (pulse_num),
        .sck_raw    (cg_raw),
        .busy       (cg_busy)
    );

    sas_streamer #(
        .DIV_W        (DIV_W),
        .DLY_W        (DLY_W),
        .DATA_W       (DATA_W),
        .EXTEND_FIRST (EXTEND_FIRST)
    ) u_str (
        .clk      (clk),
        .rst_n    (rst_n),
        .period   (period),
        .tx_go    (tx_go),
        .tx_delay (tx_delay),
        .tx_word  (tx_word),
        .tx_bits  (tx_bits),
        .sdo      (sdo),
        .busy     (st_busy)
    );

    assign sck  = cg_raw ^ cpol;
    assign busy = cg_busy | st_busy;

    assert_reset_idle_R1: assert property (@(posedge clk)
        (!rst_n) |=> (!sdo && !busy));

    assert_busy_cover_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo || (cg_raw && ck_enable)) |-> busy);

endmodule

// File: tb/tb_phase_aligned_tx.sv
`timescale 1ns/1ps
module tb_phase_aligned_tx;
    localparam int DIV_W = 5, CNT_W = 16, DLY_W = 16, DATA_W = 32;
    localparam int BITS_W = $clog2(DATA_W + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DIV_W-1:0]  period = 5'd4, high_ticks = 5'd2;
    logic cpol = 1'b0, ck_enable = 1'b0, ck_restart = 1'b0, pulse_go = 1'b0;
    logic [CNT_W-1:0]  pulse_num = '0;
    logic tx_go = 1'b0;
    logic [DLY_W-1:0]  tx_delay = '0;
    logic [DATA_W-1:0] tx_word = '0;
    logic [BITS_W-1:0] tx_bits = '0;
    logic sck, sdo, busy;

    int total = 0, bad = 0;
    logic lg_sck [0:255];
    logic lg_sdo [0:255];
    logic lg_busy[0:255];

    always #2 clk = ~clk;

    phase_aligned_tx dut (
        .clk(clk), .rst_n(rst_n), .period(period), .high_ticks(high_ticks),
        .cpol(cpol), .ck_enable(ck_enable), .ck_restart(ck_restart),
        .pulse_go(pulse_go), .pulse_num(pulse_num), .tx_go(tx_go),
        .tx_delay(tx_delay), .tx_word(tx_word), .tx_bits(tx_bits),
        .sck(sck), .sdo(sdo), .busy(busy)
    );

    task automatic chk(input string req, input string what, input int idx,
                       input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s idx=%0d actual=%b expected=%b", req, what, idx, act, exp);
        end
    endtask

    // Drop strobes after the edge that took them, then log n post-edge samples.
    task automatic capture(input int n);
        @(negedge clk);
        pulse_go = 1'b0; tx_go = 1'b0; ck_restart = 1'b0;
        for (int i = 0; i < n; i++) begin
            lg_sck[i] = sck; lg_sdo[i] = sdo; lg_busy[i] = busy;
            @(negedge clk);
        end
    endtask

    task automatic quiesce();
        @(negedge clk);
        ck_enable = 1'b0; pulse_go = 1'b0; tx_go = 1'b0; ck_restart = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    function automatic logic exp_sck(int i, int s, int p, int h, int n, logic pol);
        logic hi;
        hi = (i >= s) && ((i - s) < n * p) && (((i - s) % p) < h);
        return hi ^ pol;
    endfunction

    function automatic int first_len(int p);
        return ((p & (p - 1)) != 0) ? p + 1 : p;
    endfunction

    function automatic logic exp_sdo(int i, int dl, int p, logic [31:0] w, int nb);
        int t, k;
        if (i < dl) return 1'b0;
        t = i - dl;
        if (t < first_len(p)) return w[nb-1];
        k = 1 + (t - first_len(p)) / p;
        if (k >= nb) return 1'b0;
        return w[nb-1-k];
    endfunction

    function automatic int stream_end(int dl, int p, int nb);
        return dl + first_len(p) + (nb - 1) * p;
    endfunction

    // R1
    task automatic t_reset();
        chk("R1", "sck in reset", 0, sck, 1'b0);
        chk("R1", "sdo in reset", 0, sdo, 1'b0);
        chk("R1", "busy in reset", 0, busy, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "sck after reset", 1, sck, 1'b0);
        chk("R1", "busy after reset", 1, busy, 1'b0);
    endtask

    // R2 / R6 / R12 / R13: enable and request on the same edge
    task automatic t_train(input string req, input int pset, input int peff,
                           input int h, input int n, input logic pol);
        int len;
        quiesce();
        period = DIV_W'(pset); high_ticks = DIV_W'(h); cpol = pol;
        pulse_num = CNT_W'(n); ck_enable = 1'b1; pulse_go = 1'b1;
        len = n * peff + 2 * peff;
        capture(len);
        for (int i = 0; i < len; i++) begin
            chk(req, "sck train", i, lg_sck[i], exp_sck(i, 0, peff, h, n, pol));
            chk("R12", "busy train", i, lg_busy[i], logic'(i < n * peff));
        end
        cpol = 1'b0;
    endtask

    // R3: request mid-period on a free-running grid
    task automatic t_grid();
        int j, p, h, n, s, len;
        j = 7; p = 5; h = 2; n = 2;
        s = ((j + p - 1) / p) * p - j;
        quiesce();
        period = DIV_W'(p); high_ticks = DIV_W'(h); ck_enable = 1'b1;
        @(negedge clk);
        repeat (j - 1) @(negedge clk);
        pulse_num = CNT_W'(n); pulse_go = 1'b1;
        len = s + n * p + p;
        capture(len);
        for (int i = 0; i < len; i++) begin
            chk("R3", "sck waits for boundary", i, lg_sck[i], exp_sck(i, s, p, h, n, 1'b0));
            chk("R12", "busy pending", i, lg_busy[i], logic'(i < s + n * p));
        end
    endtask

    // R4: restart strobe with request
    task automatic t_restart();
        int p, h, n, len;
        p = 6; h = 3; n = 2;
        quiesce();
        period = DIV_W'(p); high_ticks = DIV_W'(h); ck_enable = 1'b1;
        repeat (8) @(negedge clk);
        pulse_num = CNT_W'(n); pulse_go = 1'b1; ck_restart = 1'b1;
        len = n * p + p;
        capture(len);
        for (int i = 0; i < len; i++)
            chk("R4", "sck after restart", i, lg_sck[i], exp_sck(i, 0, p, h, n, 1'b0));
    endtask

    // R5: disable drops pending pulses, re-enable brings none back
    task automatic t_disable();
        quiesce();
        period = 5'd4; high_ticks = 5'd2; ck_enable = 1'b1;
        pulse_num = CNT_W'(5); pulse_go = 1'b1;
        capture(5);
        ck_enable = 1'b0;
        pulse_go = 1'b1;
        @(negedge clk);
        pulse_go = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R5", "sck while off", i, sck, 1'b0);
            chk("R5", "busy while off", i, busy, 1'b0);
            @(negedge clk);
        end
        ck_enable = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk("R5", "no stale pulse", i, sck, 1'b0);
            chk("R5", "no stale busy", i, busy, 1'b0);
        end
    endtask

    // R7 / R8 / R9 / R10 / R12
    task automatic t_stream(input string req, input int dl, input int p,
                            input logic [31:0] w, input int nb);
        int len, e;
        quiesce();
        period = DIV_W'(p);
        tx_delay = DLY_W'(dl); tx_word = w; tx_bits = BITS_W'(nb); tx_go = 1'b1;
        e = stream_end(dl, p, nb);
        len = e + 4;
        capture(len);
        for (int i = 0; i < len; i++) begin
            chk(req, "sdo", i, lg_sdo[i], exp_sdo(i, dl, p, w, nb));
            chk("R12", "busy stream", i, lg_busy[i], logic'(i < e));
        end
    endtask

    // R11: starts during a stream and with zero bits are ignored
    task automatic t_ignore();
        int e, len;
        quiesce();
        period = 5'd3;
        tx_delay = 16'd2; tx_word = 32'hA; tx_bits = BITS_W'(4); tx_go = 1'b1;
        e = stream_end(2, 3, 4);
        len = e + 4;
        @(negedge clk);
        tx_go = 1'b1; tx_word = 32'hFFFF_FFFF; tx_bits = BITS_W'(8);
        capture(len - 1);
        for (int i = 0; i < len - 1; i++) begin
            chk("R11", "sdo unchanged", i + 1, lg_sdo[i], exp_sdo(i + 1, 2, 3, 32'hA, 4));
            chk("R11", "busy unchanged", i + 1, lg_busy[i], logic'(i + 1 < e));
        end
        tx_word = 32'h1; tx_bits = '0; tx_delay = '0; tx_go = 1'b1;
        capture(4);
        for (int i = 0; i < 4; i++) begin
            chk("R11", "zero-bit sdo", i, lg_sdo[i], 1'b0);
            chk("R11", "zero-bit busy", i, lg_busy[i], 1'b0);
        end
    endtask

    // R12: both engines together, busy holds for the longer one
    task automatic t_both();
        int p, n, e, len;
        p = 4; n = 5;
        quiesce();
        period = DIV_W'(p); high_ticks = 5'd2; ck_enable = 1'b1;
        pulse_num = CNT_W'(n); pulse_go = 1'b1;
        tx_delay = 16'd1; tx_word = 32'h5; tx_bits = BITS_W'(3); tx_go = 1'b1;
        e = n * p;
        len = e + 3;
        capture(len);
        for (int i = 0; i < len; i++) begin
            chk("R12", "busy both", i, lg_busy[i], logic'(i < e));
            chk("R9", "sdo beside clock", i, lg_sdo[i], exp_sdo(i, 1, p, 32'h5, 3));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_train("R2", 5, 5, 2, 3, 1'b0);
        t_train("R6", 4, 4, 1, 2, 1'b1);
        t_train("R13", 1, 2, 1, 3, 1'b0);
        t_train("R13", 0, 2, 1, 2, 1'b0);
        t_grid();
        t_restart();
        t_disable();
        t_stream("R7", 0, 4, 32'hB5, 8);
        t_stream("R8", 3, 4, 32'h2D, 6);
        t_stream("R10", 2, 6, 32'h96, 8);
        t_stream("R10", 0, 8, 32'h3, 2);
        t_stream("R9", 5, 2, 32'hC3A5, 16);
        t_stream("R9", 0, 20, 32'h5, 3);
        t_stream("R9", 1, 3, 32'h8000_0001, 32);
        t_ignore();
        t_both();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule